// File: doc/BRIEF.md
# Sign-and-Magnitude Adder/Subtractor

This unit adds or subtracts two numbers that each carry a separate sign bit and an unsigned magnitude field. It has a single magnitude adder, fed through a complementer, and keeps the adder's carry-out in an extend flip-flop. That carry does two jobs. When the operand signs match it flags magnitude overflow. When they differ it shows which magnitude is larger.

A caller presents both operands and an add/subtract select, then pulses `start` for one cycle. The unit takes three clock edges to finish. The first captures the operands, the second forms the raw sum or difference, and the third corrects it by recomplementing a negative difference and clearing a negative zero. A one-cycle `done` pulse then marks a valid result. The result overwrites the first operand's register and holds until the next accepted start.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `done`, `resSign`, `resMag` and `addOvf` are all 0.
- R2: The effective sign of operand B is `bSign` XOR `subOp` (subOp=1 selects subtract). For every combination of the two signs and the operation, the result equals the signed-integer value of A plus or minus B, unless overflow occurs.
- R3: When the sign of A equals the effective sign of B, the following hold: `resSign` equals `aSign`, `resMag` is the low MAG_W bits of aMag+bMag, and `addOvf` is the carry out of that sum. This includes the case -0 + -0, which gives sign 1.
- R4: When the sign of A and the effective sign of B differ, `addOvf` is 0.
- R5: With differing signs and aMag >= bMag, `resMag` = aMag - bMag and `resSign` = `aSign`, except as R7 states.
- R6: With differing signs and aMag < bMag, `resMag` = bMag - aMag and `resSign` is the inverse of `aSign`.
- R7: With differing signs and a zero result magnitude, `resSign` is 0 (no negative zero).
- R8: A start seen while idle raises `done` for exactly one cycle, after the third rising edge counted from the edge that samples `start`. A `start` seen while busy is ignored.
- R9: Between `done` and the next accepted start, `resSign`, `resMag` and `addOvf` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| subOp | input | 1 | 1 = subtract B from A, 0 = add |
| aSign | input | 1 | Sign of operand A (1 = negative) |
| aMag | input | WIDTH-1 | Magnitude of operand A |
| bSign | input | 1 | Sign of operand B (1 = negative) |
| bMag | input | WIDTH-1 | Magnitude of operand B |
| done | output | 1 | One-cycle result-valid pulse |
| resSign | output | 1 | Result sign |
| resMag | output | WIDTH-1 | Result magnitude |
| addOvf | output | 1 | Magnitude-addition overflow |

## Verification
The checker assumes that operand inputs matter only in the cycle where `start` is accepted while idle. It also assumes that no second start arrives in the same cycle as `done`, so each `done` can be matched to the one captured operand set. The stimulus changes operands only together with a fresh start, after the previous `done` has fallen. Its single deliberate violation raises `start` for a second cycle while the unit is busy, and the checker's capture logic already treats that sample as ignored.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUM  = 2'd1,
    ST_FIX  = 2'd2
  } smState_t;

  typedef struct packed {
    logic loadOps;  // capture operands, fold subtract into B sign
    logic doSum;    // add or complement-add magnitudes into {E, A}
    logic doFix;    // recomplement / negative-zero cleanup
  } smCtl_t;
endpackage

// File: rtl/sm_addsub_ctrl.sv
module sm_addsub_ctrl
  import sm_addsub_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output smCtl_t ctl,
  output logic   busy,
  output logic   done
);
  smState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.loadOps = 1'b1;
        stateNext   = ST_SUM;
      end
      ST_SUM: begin
        ctl.doSum = 1'b1;
        stateNext = ST_FIX;
      end
      ST_FIX: begin
        ctl.doFix = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_FIX);
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sm_addsub_dp.sv
module sm_addsub_dp
  import sm_addsub_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  smCtl_t           ctl,
  input  logic             subOp,
  input  logic             aSign,
  input  logic [MAG_W-1:0] aMag,
  input  logic             bSign,
  input  logic [MAG_W-1:0] bMag,
  output logic             resSign,
  output logic [MAG_W-1:0] resMag,
  output logic             addOvf
);
  logic             aSignR, bSignR, eR, avfR;
  logic [MAG_W-1:0] aR, bR;
  logic             signsDiffer;
  logic [MAG_W-1:0] bPath;
  logic [MAG_W:0]   sumExt;
  logic [MAG_W-1:0] aNeg;

  assign signsDiffer = aSignR ^ bSignR;

  // complementer in front of the shared adder; carry-in supplies the +1
  always_comb begin
    bPath  = signsDiffer ? ~bR : bR;
    sumExt = {1'b0, aR} + {1'b0, bPath} + {{MAG_W{1'b0}}, signsDiffer};
    aNeg   = ~aR + {{(MAG_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aSignR <= 1'b0;
      bSignR <= 1'b0;
      aR     <= '0;
      bR     <= '0;
      eR     <= 1'b0;
      avfR   <= 1'b0;
    end else if (ctl.loadOps) begin
      aSignR <= aSign;
      bSignR <= bSign ^ subOp;
      aR     <= aMag;
      bR     <= bMag;
      eR     <= 1'b0;
      avfR   <= 1'b0;
    end else if (ctl.doSum) begin
      {eR, aR} <= sumExt;
      avfR     <= signsDiffer ? 1'b0 : sumExt[MAG_W];
    end else if (ctl.doFix && signsDiffer) begin
      if (!eR) begin
        aR     <= aNeg;
        aSignR <= ~aSignR;
      end else if (aR == '0) begin
        aSignR <= 1'b0;
      end
    end
  end

  assign resSign = aSignR;
  assign resMag  = aR;
  assign addOvf  = avfR;
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_addsub_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int MAG_W = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             subOp,
  input  logic             aSign,
  input  logic [MAG_W-1:0] aMag,
  input  logic             bSign,
  input  logic [MAG_W-1:0] bMag,
  output logic             done,
  output logic             resSign,
  output logic [MAG_W-1:0] resMag,
  output logic             addOvf
);
  smCtl_t ctl;
  logic   ctlBusy;

  sm_addsub_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .busy (ctlBusy),
    .done (done)
  );

  sm_addsub_dp #(.MAG_W(MAG_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .subOp  (subOp),
    .aSign  (aSign),
    .aMag   (aMag),
    .bSign  (bSign),
    .bMag   (bMag),
    .resSign(resSign),
    .resMag (resMag),
    .addOvf (addOvf)
  );
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int MAG_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             subOp,
  input logic             aSign,
  input logic [MAG_W-1:0] aMag,
  input logic             bSign,
  input logic [MAG_W-1:0] bMag,
  input logic             busy,
  input logic             done,
  input logic             resSign,
  input logic [MAG_W-1:0] resMag,
  input logic             addOvf
);
  logic             cAs, cBs;
  logic [MAG_W-1:0] cA, cB;
  logic [MAG_W:0]   sumChk;
  logic             diffChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cAs <= 1'b0;
      cBs <= 1'b0;
      cA  <= '0;
      cB  <= '0;
    end else if (start && !busy) begin
      cAs <= aSign;
      cBs <= bSign ^ subOp;
      cA  <= aMag;
      cB  <= bMag;
    end
  end

  always_comb begin
    sumChk  = {1'b0, cA} + {1'b0, cB};
    diffChk = cAs ^ cBs;
  end

  // R3
  same_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !diffChk) |-> (resSign == cAs && {addOvf, resMag} == sumChk));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && diffChk) |-> !addOvf);

  // R5
  a_larger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && diffChk && cA >= cB) |-> (resMag == cA - cB));

  // R6
  b_larger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && diffChk && cA < cB) |-> (resMag == cB - cA && resSign == !cAs));

  // R7
  no_negzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && diffChk && resMag == '0) |-> !resSign);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |-> ##3 done);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(start)) |->
      ($stable(resMag) && $stable(resSign) && $stable(addOvf)));
endmodule

bind sm_addsub sm_addsub_chk #(.MAG_W(MAG_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .subOp  (subOp),
  .aSign  (aSign),
  .aMag   (aMag),
  .bSign  (bSign),
  .bMag   (bMag),
  .busy   (ctlBusy),
  .done   (done),
  .resSign(resSign),
  .resMag (resMag),
  .addOvf (addOvf)
);

// File: tb/sm_addsub_tb.sv
module sm_addsub_tb;
  localparam int W  = 5;
  localparam int MW = W - 1;
  localparam int MAXM = 1 << MW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0, subOp = 1'b0, aSign = 1'b0, bSign = 1'b0;
  logic [MW-1:0] aMag = '0, bMag = '0;
  logic          done, resSign, addOvf;
  logic [MW-1:0] resMag;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sm_addsub #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .subOp(subOp),
    .aSign(aSign), .aMag(aMag), .bSign(bSign), .bMag(bMag),
    .done(done), .resSign(resSign), .resMag(resMag), .addOvf(addOvf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one operation; holdStart keeps start high one extra (busy) cycle
  task automatic runOp(input int a, input int as, input int b, input int bs,
                       input int sub, input bit holdStart);
    int effB, expMag, expSign, expOvf, sum, va, vb, ref_, got;
    effB = bs ^ sub;
    if (as == effB) begin
      sum = a + b;
      expMag = sum % MAXM; expOvf = (sum >= MAXM) ? 1 : 0; expSign = as;
    end else if (a >= b) begin
      expMag = a - b; expOvf = 0; expSign = (a == b) ? 0 : as;
    end else begin
      expMag = b - a; expOvf = 0; expSign = 1 - as;
    end
    @(negedge clk);
    start = 1'b1; subOp = sub[0]; aSign = as[0]; bSign = bs[0];
    aMag = MW'(a); bMag = MW'(b);
    @(negedge clk);
    if (holdStart) begin
      aMag = MW'(b); bMag = MW'(a); subOp = ~subOp;
    end else start = 1'b0;
    check(done == 1'b0, "R8 early", int'(done), 0);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 early", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R8 done", int'(done), 1);
    check(int'(resMag) == expMag,
          (as == effB) ? "R3 mag" : (a >= b) ? "R5 mag" : "R6 mag", int'(resMag), expMag);
    check(int'(resSign) == expSign,
          (as == effB) ? "R3 sign" : (a == b) ? "R7 sign" : (a > b) ? "R5 sign" : "R6 sign",
          int'(resSign), expSign);
    check(int'(addOvf) == expOvf, (as == effB) ? "R3 ovf" : "R4 ovf", int'(addOvf), expOvf);
    if (expOvf == 0) begin
      va = as ? -a : a; vb = bs ? -b : b;
      ref_ = sub ? va - vb : va + vb;
      got = resSign ? -int'(resMag) : int'(resMag);
      check(got == ref_, "R2 value", got, ref_);
    end
    @(negedge clk);
    check(done == 1'b0, "R8 single", int'(done), 0);
    check(int'(resMag) == expMag && int'(resSign) == expSign, "R9 hold",
          int'(resMag), expMag);
    if (holdStart) begin
      @(negedge clk);
      check(done == 1'b0, "R8 ignored start", int'(done), 0);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(done == 0 && resSign == 0 && resMag == 0 && addOvf == 0, "R1 reset",
          int'(resMag), 0);
    rstN = 1'b1;
    // corner cases first: negative zero, equal magnitudes, overflow
    runOp(0, 1, 0, 1, 0, 0);
    runOp(0, 0, 0, 0, 1, 0);
    runOp(5, 1, 5, 0, 0, 0);
    runOp(MAXM - 1, 0, MAXM - 1, 0, 0, 0);
    runOp(3, 0, 9, 1, 1, 1);   // R8 start held while busy
    // exhaustive sweep
    for (int op = 0; op < 2; op++)
      for (int as = 0; as < 2; as++)
        for (int bs = 0; bs < 2; bs++)
          for (int a = 0; a < MAXM; a++)
            for (int b = 0; b < MAXM; b++)
              runOp(a, as, b, bs, op, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule